// File: doc/BRIEF.md
# Receive Byte Buffer with Character Timeout

This block sits between a serial receiver and the register file of a 16550-class UART. In queued mode it keeps up to sixteen received bytes and raises a flag once the fill reaches a threshold chosen by software. It detects when a byte arrives with no room, turns a detected line break into a stored zero byte, and runs a timer of four character times. When that timer expires with data still waiting, it raises a timeout-pending flag. In unqueued mode a single holding byte stands in for the queue.

Software drives the block through two kinds of write and read strobe. A control write selects the mode, the threshold and the reset actions. A data read pops the oldest byte, and a status read clears the sticky error flags. The character time comes from the live divisor and line-format inputs, so the timeout follows whatever baud rate and frame format are programmed.

Top module: `uart_rx_buffer`

## Requirements
- R1: Control bits 7:6 pick the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queued mode `trig_hit` is high while the fill is at least the threshold. In unqueued mode it follows `data_ready`.
- R2: A byte that arrives while the queue holds 16 bytes and nothing is popped in that cycle is dropped. The stored bytes and their order do not change, and `overrun` is set.
- R3: A control write whose bit 0 (queue enable) differs from the current mode applies the receive reset and pulses `tx_flush` for one cycle. A control write with bit 2 set also pulses `tx_flush`.
- R4: A control write with bit 1 set, or one that changes the mode, empties the receive storage and clears `data_ready`, `brk_flag` and `timeout_pend`. Any byte or break presented in that cycle is ignored.
- R5: A break strobe stores a 0x00 byte under the same full-queue rule as R2 and sets `brk_flag`. `data_ready` is high afterwards.
- R6: In queued mode, a received byte, or a pop that leaves data behind, restarts a countdown of L = 64 × divisor × frame-bits clock cycles. `timeout_pend` rises on the L-th edge after the restart if the queue is non-empty, unless that edge restarts the countdown again. Any pop strobe clears `timeout_pend`.
- R7: `rd_data` shows the oldest byte, or 0 when the queue is empty. A pop removes that byte. A pop that empties the queue clears `data_ready` and `brk_flag`.
- R8: Frame bits = 7 + `line_ctl[1:0]` + `line_ctl[3]` + `line_ctl[2]`, which covers the start bit, 5 to 8 data bits, the optional parity bit and 1 or 2 stop bits. A zero divisor counts as 1.
- R9: In unqueued mode, a byte arriving while `data_ready` is high, with no pop in that cycle, sets `overrun` and replaces the held byte. `rd_data` always shows the held byte.
- R10: A status-read strobe clears `brk_flag` and `overrun`, unless a new break or overrun is set in the same cycle.
- R11: After reset the block is in unqueued mode with threshold 1, empty, and every output flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control value: bit0 enable, bit1 rx reset, bit2 tx reset, bits7:6 threshold |
| rd_pop | input | 1 | Data read strobe |
| lsr_rd | input | 1 | Status read strobe |
| divisor | input | DIV_W | Baud divisor |
| line_ctl | input | 4 | Line format: [1:0] data bits − 5, [2] two stop bits, [3] parity on |
| rd_data | output | 8 | Oldest byte or held byte |
| data_ready | output | 1 | Data available |
| brk_flag | output | 1 | Break seen |
| overrun | output | 1 | Byte lost |
| trig_hit | output | 1 | Threshold reached |
| timeout_pend | output | 1 | Character timeout pending |
| tx_flush | output | 1 | One-cycle transmit reset pulse |

## Verification
Every strobe takes effect at the rising edge that samples it. The flags, `tx_flush`, the fill level and with it `rd_data` and `trig_hit` all change at that edge, so the bench drives inputs after a falling edge and reads the results at the next falling edge. The timeout is the exception: it rises exactly L edges after its restart edge. The directed checks therefore wait L−1 falling edges and expect the flag low, then wait one more and expect it high. A behavioural model that advances on the same edges is compared against every output at every falling edge.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

  // threshold in bytes for the two-bit select field
  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // bits per character: start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    return 4'd7 + {2'b00, lc[1:0]} + {3'b000, lc[3]} + {3'b000, lc[2]};
  endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 front,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] fill_q, fill_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    fill_d = fill_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      fill_d = '0;
    end else begin
      if (push) wptr_d = bump(wptr_q);
      if (pop)  rptr_d = bump(rptr_q);
      fill_d = fill_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr_q] <= push_data;
  end

  assign front = mem[rptr_q];
  assign fill  = fill_q;
endmodule

// File: rtl/rxb_char_timer.sv
module rxb_char_timer
  import uart_rxb_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       line_ctl,
  input  logic             restart,
  input  logic             cancel,
  output logic             fire
);
  localparam int TW = DIV_W + 10;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W+3:0] prod;
  logic [TW-1:0]    limit, cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    prod    = {4'b0000, div_eff} * {{DIV_W{1'b0}}, frame_bits(line_ctl)};
    limit   = {prod, 6'b000000};
  end

  assign fire = run_q && (cnt_q == TW'(1)) && !restart && !cancel;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (cancel) begin
      run_d = 1'b0;
    end else if (restart) begin
      run_d = 1'b1;
      cnt_d = limit;
    end else if (run_q) begin
      if (cnt_q == TW'(1)) run_d = 1'b0;
      else                 cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_break,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_data,
  input  logic             rd_pop,
  input  logic             lsr_rd,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       line_ctl,
  output logic [7:0]       rd_data,
  output logic             data_ready,
  output logic             brk_flag,
  output logic             overrun,
  output logic             trig_hit,
  output logic             timeout_pend,
  output logic             tx_flush
);
  localparam int CW = $clog2(DEPTH+1);

  logic          fifo_en_q, fifo_en_d;
  logic [1:0]    trig_sel_q, trig_sel_d;
  logic [7:0]    hold_q, hold_d;
  logic          hdr_q, hdr_d, brk_q, brk_d, ovr_q, ovr_d, tmo_q, tmo_d, txf_q, txf_d;
  logic          rx_clr, in_evt, pop_ok, push_ok, drop, hold_ovr, restart_t, fire;
  logic [7:0]    in_byte, front;
  logic [CW-1:0] fill, fill_after_pop, level;
  logic          unused_ctl;

  assign unused_ctl = ^ctl_data[5:3];

  // control decode
  assign rx_clr  = ctl_wr && (ctl_data[1] || (ctl_data[0] != fifo_en_q));
  assign txf_d   = ctl_wr && (ctl_data[2] || (ctl_data[0] != fifo_en_q));
  assign in_evt  = rx_valid || rx_break;
  assign in_byte = rx_break ? 8'h00 : rx_byte;
  assign level   = CW'(trig_bytes(trig_sel_q));

  // queued-mode data path
  assign pop_ok         = fifo_en_q && rd_pop && (fill != '0) && !rx_clr;
  assign fill_after_pop = fill - CW'(pop_ok);
  assign push_ok        = fifo_en_q && in_evt && !rx_clr && (fill_after_pop < CW'(DEPTH));
  assign drop           = fifo_en_q && in_evt && !rx_clr && (fill_after_pop >= CW'(DEPTH));
  assign hold_ovr       = !fifo_en_q && in_evt && !rx_clr && hdr_q && !rd_pop;
  assign restart_t      = fifo_en_q && !rx_clr && (rx_valid || (pop_ok && (fill > CW'(1))));

  rxb_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .push      (push_ok),
    .push_data (in_byte),
    .pop       (pop_ok),
    .front     (front),
    .fill      (fill)
  );

  rxb_char_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .divisor  (divisor),
    .line_ctl (line_ctl),
    .restart  (restart_t),
    .cancel   (rx_clr),
    .fire     (fire)
  );

  always_comb begin
    fifo_en_d  = ctl_wr ? ctl_data[0]   : fifo_en_q;
    trig_sel_d = ctl_wr ? ctl_data[7:6] : trig_sel_q;

    hold_d = hold_q;
    hdr_d  = hdr_q;
    if (rx_clr) begin
      hdr_d = 1'b0;
    end else if (!fifo_en_q) begin
      if (in_evt) begin
        hold_d = in_byte;
        hdr_d  = 1'b1;
      end else if (rd_pop) begin
        hdr_d  = 1'b0;
      end
    end

    brk_d = brk_q;
    if (rx_clr)                                   brk_d = 1'b0;
    else if (rx_break)                            brk_d = 1'b1;
    else if (lsr_rd)                              brk_d = 1'b0;
    else if (fifo_en_q && pop_ok && fill == CW'(1)) brk_d = 1'b0;
    else if (!fifo_en_q && rd_pop)                brk_d = 1'b0;

    ovr_d = ovr_q;
    if (drop || hold_ovr) ovr_d = 1'b1;
    else if (lsr_rd)      ovr_d = 1'b0;

    tmo_d = tmo_q;
    if (rx_clr || rd_pop)                      tmo_d = 1'b0;
    else if (fire && fifo_en_q && fill != '0) tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q  <= 1'b0;
      trig_sel_q <= 2'b00;
      hold_q     <= 8'h00;
      hdr_q      <= 1'b0;
      brk_q      <= 1'b0;
      ovr_q      <= 1'b0;
      tmo_q      <= 1'b0;
      txf_q      <= 1'b0;
    end else begin
      fifo_en_q  <= fifo_en_d;
      trig_sel_q <= trig_sel_d;
      hold_q     <= hold_d;
      hdr_q      <= hdr_d;
      brk_q      <= brk_d;
      ovr_q      <= ovr_d;
      tmo_q      <= tmo_d;
      txf_q      <= txf_d;
    end
  end

  assign rd_data      = fifo_en_q ? ((fill != '0) ? front : 8'h00) : hold_q;
  assign data_ready   = fifo_en_q ? (fill != '0) : hdr_q;
  assign trig_hit     = fifo_en_q ? (fill >= level) : hdr_q;
  assign brk_flag     = brk_q;
  assign overrun      = ovr_q;
  assign timeout_pend = tmo_q;
  assign tx_flush     = txf_q;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       rx_break,
  input logic                       ctl_wr,
  input logic [7:0]                 ctl_data,
  input logic                       rd_pop,
  input logic                       lsr_rd,
  input logic                       fifo_en,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       brk_flag,
  input logic                       overrun,
  input logic                       timeout_pend,
  input logic                       tx_flush
);
  localparam int CW = $clog2(DEPTH+1);

  // R2: a byte into a full queue is lost and the fill stays at the top
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (rx_valid || rx_break) && !rd_pop && !ctl_wr && fill == CW'(DEPTH))
      |=> (overrun && fill == CW'(DEPTH)));

  // R3: a mode change flushes both directions
  a_r3_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_data[0] != fifo_en)) |=> (tx_flush && fill == '0));

  // R4: a receive reset clears storage and flags
  a_r4_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[1]) |=> (fill == '0 && !brk_flag && !timeout_pend));

  // R6: any pop clears the pending timeout
  a_r6_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !timeout_pend);

  // R6: a timeout is only raised with data waiting
  a_r6_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> (fill != '0));

  // R10: a status read clears the sticky flags when nothing new arrives
  a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !brk_flag));
endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .ctl_wr       (ctl_wr),
  .ctl_data     (ctl_data),
  .rd_pop       (rd_pop),
  .lsr_rd       (lsr_rd),
  .fifo_en      (fifo_en_q),
  .fill         (fill),
  .brk_flag     (brk_flag),
  .overrun      (overrun),
  .timeout_pend (timeout_pend),
  .tx_flush     (tx_flush)
);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_break, ctl_wr, rd_pop, lsr_rd;
  logic [7:0]  rx_byte, ctl_data;
  logic [15:0] divisor;
  logic [3:0]  line_ctl;
  logic [7:0]  rd_data;
  logic        data_ready, brk_flag, overrun, trig_hit, timeout_pend, tx_flush;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH), .DIV_W(16)) u0 (
    .clk, .rst_n, .rx_valid, .rx_byte, .rx_break, .ctl_wr, .ctl_data,
    .rd_pop, .lsr_rd, .divisor, .line_ctl, .rd_data, .data_ready,
    .brk_flag, .overrun, .trig_hit, .timeout_pend, .tx_flush
  );

  // ---------------- reference model ----------------
  byte unsigned q[$];
  bit          m_ok = 0;
  bit          m_en, m_hdr, m_brk, m_ovr, m_tmo, m_txf, m_armed;
  bit [1:0]    m_sel;
  byte unsigned m_hold;
  longint      m_cyc, m_deadline;

  function automatic int lvl_of(bit [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  function automatic longint span_of(logic [15:0] d, logic [3:0] lc);
    int fb = 7 + lc[1:0] + lc[3] + lc[2];
    int de = (d == 0) ? 1 : d;
    return 64 * de * fb;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_en = 0; m_sel = 0; m_hold = 0; m_hdr = 0; m_brk = 0; m_ovr = 0;
      m_tmo = 0; m_txf = 0; m_armed = 0; m_cyc = 0; m_deadline = 0; m_ok = 1;
    end else begin
      automatic int n = q.size();
      automatic bit clr = ctl_wr && (ctl_data[1] || (ctl_data[0] != m_en));
      automatic bit txf = ctl_wr && (ctl_data[2] || (ctl_data[0] != m_en));
      automatic bit fire = m_armed && (m_cyc == m_deadline);
      automatic bit restart = 0, setovr = 0, popempty = 0;
      if (clr) begin
        q.delete(); m_brk = 0; m_tmo = 0; m_hdr = 0; m_armed = 0;
      end else begin
        if (m_en) begin
          if (rd_pop && n > 0) begin
            void'(q.pop_front());
            if (n > 1) restart = 1; else popempty = 1;
          end
          if (rx_valid || rx_break) begin
            if (q.size() < DEPTH) q.push_back(rx_break ? 8'h00 : rx_byte);
            else setovr = 1;
          end
          if (rx_valid) restart = 1;
        end else begin
          if (rx_valid || rx_break) begin
            if (m_hdr && !rd_pop) setovr = 1;
            m_hold = rx_break ? 8'h00 : rx_byte;
            m_hdr = 1;
          end else if (rd_pop) m_hdr = 0;
        end
        if (rx_break) m_brk = 1;
        else if (lsr_rd) m_brk = 0;
        else if (m_en ? popempty : rd_pop) m_brk = 0;
        if (rd_pop) m_tmo = 0;
        else if (fire && !restart && m_en && n > 0) m_tmo = 1;
        if (restart) begin m_armed = 1; m_deadline = m_cyc + span_of(divisor, line_ctl); end
        else if (fire) m_armed = 0;
      end
      if (setovr) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
      m_txf = txf;
      if (ctl_wr) begin m_en = ctl_data[0]; m_sel = ctl_data[7:6]; end
      m_cyc++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_ok) begin
      check("R7 rd_data", rd_data, m_en ? (q.size() ? q[0] : 0) : m_hold);
      check("R7 data_ready", data_ready, m_en ? (q.size() != 0) : m_hdr);
      check("R1 trig_hit", trig_hit, m_en ? (q.size() >= lvl_of(m_sel)) : m_hdr);
      check("R5 brk_flag", brk_flag, m_brk);
      check("R2 overrun", overrun, m_ovr);
      check("R6 timeout_pend", timeout_pend, m_tmo);
      check("R3 tx_flush", tx_flush, m_txf);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(negedge clk); endtask
  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; tick(); rx_valid = 0;
  endtask
  task automatic do_break(); rx_break = 1; tick(); rx_break = 0; endtask
  task automatic pop(); rd_pop = 1; tick(); rd_pop = 0; endtask
  task automatic lsr(); lsr_rd = 1; tick(); lsr_rd = 0; endtask
  task automatic ctl(input logic [7:0] v); ctl_wr = 1; ctl_data = v; tick(); ctl_wr = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_break = 0; ctl_wr = 0; rd_pop = 0; lsr_rd = 0;
    rx_byte = 0; ctl_data = 0; divisor = 16'd1; line_ctl = 4'h0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    check("R11 dr", data_ready, 0);
    check("R11 flags", {brk_flag, overrun, trig_hit, timeout_pend, tx_flush}, 0);
    check("R11 rd_data", rd_data, 0);

    // R9 holding mode
    send(8'hA5);
    check("R9 held", rd_data, 8'hA5);
    check("R9 dr", data_ready, 1);
    send(8'h3C);
    check("R9 overrun", overrun, 1);
    check("R9 replaced", rd_data, 8'h3C);
    lsr();
    check("R10 ovr clear", overrun, 0);
    pop();
    check("R9 dr clear", data_ready, 0);
    do_break();
    check("R5 hold brk", brk_flag, 1);
    lsr();
    check("R10 brk clear", brk_flag, 0);
    pop();

    // R3 enable toggle, threshold 4
    ctl(8'h41);
    check("R3 flush pulse", tx_flush, 1);
    tick();
    check("R3 pulse ends", tx_flush, 0);
    send(8'h11); send(8'h22); send(8'h33);
    check("R1 below 4", trig_hit, 0);
    send(8'h44);
    check("R1 at 4", trig_hit, 1);
    check("R7 front", rd_data, 8'h11);
    pop();
    check("R7 next", rd_data, 8'h22);
    pop(); pop(); pop();
    check("R7 empty dr", data_ready, 0);
    check("R7 empty data", rd_data, 0);
    pop();
    check("R7 pop empty", rd_data, 0);

    // R2 full queue
    for (int i = 0; i < DEPTH; i++) send(8'h50 + 8'(i));
    send(8'hEE);
    check("R2 overrun", overrun, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 kept", rd_data, 8'h50 + i);
      pop();
    end
    check("R2 drained", data_ready, 0);
    lsr();

    // R5 break in queued mode
    do_break();
    check("R5 zero", rd_data, 0);
    check("R5 brk", brk_flag, 1);
    check("R5 dr", data_ready, 1);
    send(8'h77);
    pop();
    check("R7 brk stays", brk_flag, 1);
    pop();
    check("R7 brk cleared", brk_flag, 0);

    // R6 / R8 timeout, 7-bit frame, divisor 1 -> 448
    send(8'h99);
    repeat (447) tick();
    check("R8 before", timeout_pend, 0);
    tick();
    check("R6 raised", timeout_pend, 1);
    pop();
    check("R6 read clears", timeout_pend, 0);

    // R8 12-bit frame, divisor 2 -> 1536
    divisor = 16'd2; line_ctl = 4'hF;
    send(8'h5A);
    repeat (1535) tick();
    check("R8 long before", timeout_pend, 0);
    tick();
    check("R8 long raised", timeout_pend, 1);
    pop();

    // R6 pop leaving data restarts the countdown
    divisor = 16'd1; line_ctl = 4'h0;
    send(8'h01); send(8'h02);
    repeat (100) tick();
    pop();
    repeat (447) tick();
    check("R6 restart before", timeout_pend, 0);
    tick();
    check("R6 restart raised", timeout_pend, 1);

    // R4 receive reset
    do_break();
    ctl(8'h43);
    check("R4 dr", data_ready, 0);
    check("R4 brk", brk_flag, 0);
    check("R4 tmo", timeout_pend, 0);
    check("R4 no tx pulse", tx_flush, 0);

    // R1 thresholds 14 and 8
    ctl(8'hC1);
    for (int i = 0; i < 13; i++) send(8'(i));
    check("R1 below 14", trig_hit, 0);
    send(8'h0D);
    check("R1 at 14", trig_hit, 1);
    ctl(8'h81);
    check("R1 level 8", trig_hit, 1);

    // R3 disable flushes, then tx-only reset
    ctl(8'h80);
    check("R3 disable flush", tx_flush, 1);
    check("R3 disable empties", data_ready, 0);
    ctl(8'h04);
    check("R3 tx reset", tx_flush, 1);
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule